// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Controller

This block is the digital core of a supply supervisor. External comparators have already digitized each monitored rail into one undervoltage flag (`1` means below threshold). The block turns those flags into one active-low status output per rail and one combined active-low system reset. It also takes an active-low manual reset with glitch rejection, a supply-lockout flag, an active-low margin-test input and a one-cycle watchdog-expiry pulse.

The combined reset is held for a programmable number of clock ticks after every cause has cleared. Any cause that appears during that hold restarts the count from zero. The margin input, once it has been stable for a programmable delay, forces every output inactive (high). A watchdog expiry that arrives while that override is in effect is remembered and applied as soon as the override lifts. All time values are parameters in clock ticks. The rail count is a parameter of 4, 6 or 8, and internally unused rail slots are tied to the good state.

Top module: `rail_supervisor`

## Requirements
- R1: While `lockout` is 0 and no margin override is in effect, `rail_stat_n[i]` equals `~rail_low[i]` in the same cycle, with no added timeout (bit i = 1 on `rail_low` means rail i is below threshold; bit i = 1 on `rail_stat_n` means rail i is good).
- R2: When any `rail_low` bit is 1 at a clock edge and neither lockout nor margin override applies, `sys_rst_n` is 0 after that edge.
- R3: Once every cause (rail low, qualified manual reset, lockout, watchdog) is absent, `sys_rst_n` rises exactly `TIMEOUT` clock edges later, counting the first edge that sees all causes clear.
- R4: A cause present at any edge of the hold, including the edge on which the hold would have ended, keeps `sys_rst_n` low and restarts the full `TIMEOUT` count.
- R5: While `lockout` is 1, `sys_rst_n` and every `rail_stat_n` bit are 0 in the same cycle whatever the rails show. Lockout also counts as a cause, so `sys_rst_n` rises `TIMEOUT` edges after lockout clears.
- R6: When `margin_n` is held at 0 for `MARGIN_DLY` edges, `sys_rst_n` and all `rail_stat_n` bits read 1 from that edge on. After `margin_n` returns to 1 for `MARGIN_DLY` edges, the outputs follow their normal values again.
- R7: A `margin_n` low pulse shorter than `MARGIN_DLY` edges has no effect on any output.
- R8: A one-cycle `wdog_exp` pulse with no override drives `sys_rst_n` to 0 after that edge, and `sys_rst_n` returns to 1 `TIMEOUT` edges later.
- R9: A `wdog_exp` pulse during a margin override leaves the outputs high. `sys_rst_n` then falls `MARGIN_DLY + 1` edges after `margin_n` returns to 1.
- R10: A `man_rst_n` low pulse seen on fewer than `GLITCH_TICKS` consecutive edges has no effect on `sys_rst_n`.
- R11: A `man_rst_n` low held long enough drives `sys_rst_n` to 0 on the `GLITCH_TICKS + MR_DLY + 1`th edge. After `man_rst_n` returns high, `sys_rst_n` rises on the `TIMEOUT + MR_DLY + 1`th edge.
- R12: While `rst_n` is 0, `sys_rst_n` is 0. After `rst_n` is released with no cause present, `sys_rst_n` rises `TIMEOUT` edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| rail_low | input | NUM_RAILS | Per-rail undervoltage flag, 1 = below threshold |
| man_rst_n | input | 1 | Active-low manual reset request |
| lockout | input | 1 | Supply-lockout flag, 1 = forces all outputs low |
| margin_n | input | 1 | Active-low margin-test request |
| wdog_exp | input | 1 | One-cycle watchdog-expiry pulse |
| rail_stat_n | output | NUM_RAILS | Per-rail status, 0 = rail below threshold |
| sys_rst_n | output | 1 | Combined active-low system reset |

## Verification
Two functions can act on the same clock edge: the hold counter reaching its terminal count, and a fresh cause arriving. The bench provokes this by raising a rail flag exactly on the edge where the hold would end. It then checks that `sys_rst_n` never rises and that a full `TIMEOUT` count starts again. A second collision puts a watchdog expiry into a margin override. This is judged by the reset appearing exactly `MARGIN_DLY + 1` edges after release. A cycle-level bench model covers the random mixes in which these collisions occur by chance.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   // Widest rail count the block supports; unused slots are tied good.
   localparam int MAX_RAILS = 8;

   // Counter width able to hold the value n.
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/rsv_mr_filter.sv
module rsv_mr_filter #(
   parameter int GLITCH_TICKS = 4,
   parameter int MR_DLY       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic man_rst_n,
   output logic mr_cause
);
   import rsv_pkg::*;

   localparam int RW = cnt_bits(GLITCH_TICKS);
   localparam logic [RW-1:0] RUN_SAT = RW'(GLITCH_TICKS);
   localparam logic [RW-1:0] RUN_QUAL = RW'(GLITCH_TICKS - 1);

   logic [RW-1:0] run_q;
   logic          qual_q;

   // Count consecutive low samples; qualify once GLITCH_TICKS are seen.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         qual_q <= 1'b0;
      end else if (man_rst_n) begin
         run_q  <= '0;
         qual_q <= 1'b0;
      end else begin
         if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
         qual_q <= (run_q >= RUN_QUAL);
      end
   end

   generate
      if (MR_DLY == 0) begin : g_nodly
         assign mr_cause = qual_q;
      end else begin : g_dly
         logic [MR_DLY-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= qual_q;
               for (int k = 1; k < MR_DLY; k++) sh_q[k] <= sh_q[k-1];
            end
         end
         assign mr_cause = sh_q[MR_DLY-1];
      end
   endgenerate
endmodule

// File: rtl/rsv_margin_ctl.sv
module rsv_margin_ctl #(
   parameter int MARGIN_DLY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic margin_n,
   output logic ovr_q
);
   import rsv_pkg::*;

   localparam int MW = cnt_bits(MARGIN_DLY);
   localparam logic [MW-1:0] FLIP_AT = MW'(MARGIN_DLY - 1);

   logic [MW-1:0] dis_q;
   logic          want;

   assign want = ~margin_n;

   // The override follows the request only after it has disagreed for
   // MARGIN_DLY consecutive edges; any agreement restarts the count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         dis_q <= '0;
      end else if (want == ovr_q) begin
         dis_q <= '0;
      end else if (dis_q == FLIP_AT) begin
         ovr_q <= want;
         dis_q <= '0;
      end else begin
         dis_q <= dis_q + 1'b1;
      end
   end
endmodule

// File: rtl/rsv_reset_timer.sv
module rsv_reset_timer #(
   parameter int TIMEOUT = 20
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cause,
   output logic                               hold_q,
   output logic [rsv_pkg::cnt_bits(TIMEOUT)-1:0] cnt_q
);
   import rsv_pkg::*;

   localparam int TW = cnt_bits(TIMEOUT);
   localparam logic [TW-1:0] TERM = TW'(TIMEOUT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b1;
         cnt_q  <= '0;
      end else if (cause) begin
         hold_q <= 1'b1;
         cnt_q  <= '0;
      end else if (hold_q) begin
         if (cnt_q == TERM) hold_q <= 1'b0;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
   parameter int NUM_RAILS    = 6,
   parameter int TIMEOUT      = 20,
   parameter int MARGIN_DLY   = 5,
   parameter int GLITCH_TICKS = 4,
   parameter int MR_DLY       = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] rail_low,
   input  logic                 man_rst_n,
   input  logic                 lockout,
   input  logic                 margin_n,
   input  logic                 wdog_exp,
   output logic [NUM_RAILS-1:0] rail_stat_n,
   output logic                 sys_rst_n
);
   import rsv_pkg::*;

   localparam int TW = cnt_bits(TIMEOUT);

   generate
      if (!(NUM_RAILS == 4 || NUM_RAILS == 6 || NUM_RAILS == 8)) begin : g_bad_rails
         $error("rail_supervisor: NUM_RAILS must be 4, 6 or 8");
      end
      if (TIMEOUT < 2) begin : g_bad_tmo
         $error("rail_supervisor: TIMEOUT must be at least 2");
      end
      if (MARGIN_DLY < 1 || GLITCH_TICKS < 1 || MR_DLY < 0) begin : g_bad_dly
         $error("rail_supervisor: delay parameters out of range");
      end
   endgenerate

   // Full-width rail vector; slots past NUM_RAILS read as good.
   logic [MAX_RAILS-1:0] rail_low_full;
   genvar gi;
   generate
      for (gi = 0; gi < MAX_RAILS; gi++) begin : g_rail
         if (gi < NUM_RAILS) begin : g_used
            assign rail_low_full[gi] = rail_low[gi];
         end else begin : g_tied
            assign rail_low_full[gi] = 1'b0;
         end
      end
   endgenerate

   logic          mr_cause;
   logic          ovr_q;
   logic          hold_q;
   logic [TW-1:0] cnt_q;
   logic          wd_pend_q;
   logic          wd_cause;
   logic          any_rail_low;
   logic          cause;

   rsv_mr_filter #(
      .GLITCH_TICKS(GLITCH_TICKS),
      .MR_DLY      (MR_DLY)
   ) u_mr (
      .clk      (clk),
      .rst_n    (rst_n),
      .man_rst_n(man_rst_n),
      .mr_cause (mr_cause)
   );

   rsv_margin_ctl #(
      .MARGIN_DLY(MARGIN_DLY)
   ) u_margin (
      .clk     (clk),
      .rst_n   (rst_n),
      .margin_n(margin_n),
      .ovr_q   (ovr_q)
   );

   // Watchdog expiries seen under override wait until it lifts.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wd_pend_q <= 1'b0;
      else if (ovr_q) wd_pend_q <= wd_pend_q | wdog_exp;
      else            wd_pend_q <= 1'b0;
   end

   assign wd_cause     = ~ovr_q & (wdog_exp | wd_pend_q);
   assign any_rail_low = |rail_low_full;
   assign cause        = any_rail_low | mr_cause | lockout | wd_cause;

   rsv_reset_timer #(
      .TIMEOUT(TIMEOUT)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cause (cause),
      .hold_q(hold_q),
      .cnt_q (cnt_q)
   );

   // Output priority: lockout low, then margin high, then normal.
   always_comb begin
      if (lockout) begin
         sys_rst_n   = 1'b0;
         rail_stat_n = '0;
      end else if (ovr_q) begin
         sys_rst_n   = 1'b1;
         rail_stat_n = '1;
      end else begin
         sys_rst_n   = ~hold_q;
         rail_stat_n = ~rail_low_full[NUM_RAILS-1:0];
      end
   end
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
   parameter int NUM_RAILS = 6,
   parameter int TIMEOUT   = 20,
   parameter int TW        = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_RAILS-1:0] rail_low,
   input logic                 lockout,
   input logic [NUM_RAILS-1:0] rail_stat_n,
   input logic                 sys_rst_n,
   input logic                 ovr_q,
   input logic                 hold_q,
   input logic [TW-1:0]        cnt_q,
   input logic                 cause,
   input logic                 wd_pend_q
);
   localparam int CW = rsv_pkg::cnt_bits(TIMEOUT);
   localparam logic [CW-1:0] CLR_SAT = CW'(TIMEOUT);

   // Independent count of consecutive cause-free edges.
   logic [CW-1:0] clr_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                clr_run <= '0;
      else if (cause)            clr_run <= '0;
      else if (clr_run != CLR_SAT) clr_run <= clr_run + 1'b1;
   end

   a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (!lockout && !ovr_q) |-> (rail_stat_n == ~rail_low));

   a_r2_rail_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      (|rail_low) |=> (lockout || ovr_q || !sys_rst_n));

   a_r3_full_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q) |-> (clr_run == CLR_SAT));

   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      cause |=> (hold_q && cnt_q == '0));

   a_r5_lockout_low: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |-> (!sys_rst_n && rail_stat_n == '0));

   a_r6_margin_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !lockout) |-> (sys_rst_n && (&rail_stat_n)));

   a_r9_deferred_wdog: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ovr_q) && wd_pend_q) |=> hold_q);
endmodule

bind rail_supervisor rsv_checker #(
   .NUM_RAILS(NUM_RAILS),
   .TIMEOUT  (TIMEOUT),
   .TW       (rsv_pkg::cnt_bits(TIMEOUT))
) u_rsv_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rail_low   (rail_low),
   .lockout    (lockout),
   .rail_stat_n(rail_stat_n),
   .sys_rst_n  (sys_rst_n),
   .ovr_q      (ovr_q),
   .hold_q     (hold_q),
   .cnt_q      (cnt_q),
   .cause      (cause),
   .wd_pend_q  (wd_pend_q)
);

// File: tb/tb_rail_supervisor.sv
`timescale 1ns/1ps
module tb_rail_supervisor;
   localparam int NR  = 6;
   localparam int T   = 20;
   localparam int MD  = 5;
   localparam int G   = 4;
   localparam int MRD = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] rail_low = '0;
   logic          man_rst_n = 1'b1;
   logic          lockout = 1'b0;
   logic          margin_n = 1'b1;
   logic          wdog_exp = 1'b0;
   logic [NR-1:0] rail_stat_n;
   logic          sys_rst_n;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   rail_supervisor #(
      .NUM_RAILS(NR), .TIMEOUT(T), .MARGIN_DLY(MD),
      .GLITCH_TICKS(G), .MR_DLY(MRD)
   ) dut (
      .clk(clk), .rst_n(rst_n), .rail_low(rail_low), .man_rst_n(man_rst_n),
      .lockout(lockout), .margin_n(margin_n), .wdog_exp(wdog_exp),
      .rail_stat_n(rail_stat_n), .sys_rst_n(sys_rst_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Edges until sys_rst_n shows value v (sampled at negedge).
   task automatic edges_sys(input logic v, output int n);
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (sys_rst_n !== v && n < 1000);
   endtask

   task automatic edges_stat(input logic [NR-1:0] v, output int n);
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (rail_stat_n !== v && n < 1000);
   endtask

   // ---------------- cycle model built from the requirements ----------
   int       m_low, m_mrun, m_rem;
   bit       m_qual, m_ovr, m_pend, m_hold;
   bit [MRD-1:0] m_sh;

   always @(posedge clk or negedge rst_n) begin
      bit c;
      if (!rst_n) begin
         m_low = 0; m_mrun = 0; m_rem = T; m_qual = 0;
         m_ovr = 0; m_pend = 0; m_hold = 1; m_sh = '0;
      end else begin
         c = (|rail_low) | m_sh[MRD-1] | lockout |
             (!m_ovr & (wdog_exp | m_pend));
         if (c) begin m_hold = 1; m_rem = T; end
         else if (m_hold) begin
            m_rem--;
            if (m_rem == 0) m_hold = 0;
         end
         m_pend = m_ovr ? (m_pend | wdog_exp) : 1'b0;
         if ((!margin_n) != m_ovr) begin
            m_mrun++;
            if (m_mrun == MD) begin m_ovr = !margin_n; m_mrun = 0; end
         end else m_mrun = 0;
         for (int k = MRD-1; k > 0; k--) m_sh[k] = m_sh[k-1];
         m_sh[0] = m_qual;
         m_low  = man_rst_n ? 0 : ((m_low < G) ? m_low + 1 : G);
         m_qual = (m_low >= G);
      end
   end

   // Continuous comparison against the model, away from the clock edge.
   always @(negedge clk) begin
      logic [NR-1:0] es;
      logic          ey;
      if (rst_n) begin
         es = lockout ? '0 : (m_ovr ? '1 : ~rail_low);
         ey = lockout ? 1'b0 : (m_ovr ? 1'b1 : !m_hold);
         if (lockout) begin
            chk(rail_stat_n === es && sys_rst_n === ey, "R5 model", {rail_stat_n, sys_rst_n}, {es, ey});
         end else if (m_ovr) begin
            chk(rail_stat_n === es && sys_rst_n === ey, "R6 model", {rail_stat_n, sys_rst_n}, {es, ey});
         end else begin
            chk(rail_stat_n === es, "R1 model", rail_stat_n, es);
            chk(sys_rst_n === ey, "R3 model", sys_rst_n, ey);
         end
      end
   end

   initial begin
      int n;
      void'($urandom(32'd2024));

      // R12: reset state and release
      repeat (4) @(negedge clk);
      chk(sys_rst_n === 1'b0, "R12 reset low", sys_rst_n, 0);
      rst_n = 1'b1;
      edges_sys(1'b1, n);
      chk(n == T, "R12 release delay", n, T);

      // R1 pass-through, R2 assert, R3 timeout
      rail_low = 6'b000101;
      #1 chk(rail_stat_n === ~6'b000101, "R1 pass-through", rail_stat_n, ~6'b000101);
      edges_sys(1'b0, n);
      chk(n == 1, "R2 rail asserts", n, 1);
      rail_low = '0;
      #1 chk(rail_stat_n === '1, "R1 return high", rail_stat_n, 6'h3f);
      edges_sys(1'b1, n);
      chk(n == T, "R3 timeout", n, T);

      // R4: cause on the terminal edge
      rail_low = 6'b100000;
      @(negedge clk);
      rail_low = '0;
      repeat (T-1) @(negedge clk);
      rail_low = 6'b010000;
      @(negedge clk);
      chk(sys_rst_n === 1'b0, "R4 terminal collision", sys_rst_n, 0);
      rail_low = '0;
      edges_sys(1'b1, n);
      chk(n == T, "R4 reload full count", n, T);

      // R8 watchdog
      wdog_exp = 1'b1;
      edges_sys(1'b0, n);
      chk(n == 1, "R8 watchdog asserts", n, 1);
      wdog_exp = 1'b0;
      edges_sys(1'b1, n);
      chk(n == T, "R8 watchdog hold", n, T);

      // R10 manual reset glitch
      man_rst_n = 1'b0;
      repeat (G-1) @(negedge clk);
      man_rst_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(sys_rst_n === 1'b1, "R10 glitch ignored", sys_rst_n, 1);
      end

      // R11 qualified manual reset
      man_rst_n = 1'b0;
      edges_sys(1'b0, n);
      chk(n == G + MRD + 1, "R11 assert latency", n, G + MRD + 1);
      repeat (3) @(negedge clk);
      man_rst_n = 1'b1;
      edges_sys(1'b1, n);
      chk(n == T + MRD + 1, "R11 release latency", n, T + MRD + 1);

      // R5 lockout
      rail_low = 6'b000010;
      lockout = 1'b1;
      #1 chk(sys_rst_n === 1'b0 && rail_stat_n === '0, "R5 lockout forces low", rail_stat_n, 0);
      rail_low = '0;
      repeat (3) @(negedge clk);
      lockout = 1'b0;
      edges_sys(1'b1, n);
      chk(n == T, "R5 lockout release", n, T);

      // R7 short margin pulse ignored
      rail_low = 6'b000011;
      margin_n = 1'b0;
      repeat (MD-1) @(negedge clk);
      margin_n = 1'b1;
      for (int i = 0; i < 2*MD; i++) begin
         @(negedge clk);
         chk(rail_stat_n === ~6'b000011, "R7 short margin ignored", rail_stat_n, ~6'b000011);
      end

      // R6 margin override apply and release
      margin_n = 1'b0;
      edges_stat('1, n);
      chk(n == MD, "R6 override delay", n, MD);
      chk(sys_rst_n === 1'b1, "R6 reset forced high", sys_rst_n, 1);
      margin_n = 1'b1;
      edges_stat(~6'b000011, n);
      chk(n == MD, "R6 release delay", n, MD);
      chk(sys_rst_n === 1'b0, "R6 reset back low", sys_rst_n, 0);
      rail_low = '0;
      edges_sys(1'b1, n);

      // R9 watchdog during override
      margin_n = 1'b0;
      repeat (MD + 2) @(negedge clk);
      wdog_exp = 1'b1;
      @(negedge clk);
      wdog_exp = 1'b0;
      repeat (3) @(negedge clk);
      chk(sys_rst_n === 1'b1, "R9 held under override", sys_rst_n, 1);
      margin_n = 1'b1;
      edges_sys(1'b0, n);
      chk(n == MD + 1, "R9 deferred assert", n, MD + 1);
      edges_sys(1'b1, n);

      // Constrained random mix, checked by the model comparator
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         for (int r = 0; r < NR; r++) rail_low[r] = ($urandom_range(0, 39) == 0);
         if ($urandom_range(0, 9) == 0) man_rst_n = ~man_rst_n;
         wdog_exp = ($urandom_range(0, 199) == 0);
         if ($urandom_range(0, 59) == 0) margin_n = ~margin_n;
         lockout  = ($urandom_range(0, 299) == 0) ? ~lockout : lockout;
      end
      rail_low = '0; man_rst_n = 1'b1; wdog_exp = 1'b0;
      margin_n = 1'b1; lockout = 1'b0;
      repeat (T + 20) @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule